// File: doc/BRIEF.md
# Per-Channel Conversion Trigger Selector

This block decides, every clock, which analog input channels receive a start-of-conversion request. It holds a 32-bit source register made of eight 4-bit fields, one per channel. Each field routes one of several trigger sources to its channel: a self-clearing software pulse, a level software control, a scan trigger gated by a per-channel scan mask, a synchronous trigger input, or one of eleven event inputs. Every channel is independent, so channels can follow different sources, and several channels may follow the same one.

A small register bus writes and reads the source field register, a control register and the scan mask. While the converter is enabled, the source register is frozen and a write to it returns an error. A software-conversion override silences all routed triggers. The per-channel output is a single-cycle request pulse taken from the rising edge of the qualified trigger level, so a trigger that is held high starts only one conversion.

Top module: `trig_route_top`

## Requirements
- R1: After reset the source register, control register and scan mask all read 0, and `start_req` is 0.
- R2: Channel k's source code sits in bits 4k+3:4k of the source register (address 0). A write while the enable bit is 0 is stored, and a read returns it.
- R3: Address map: 0 = source register, 1 = control (bit0 enable, bit1 event-start enable, bit2 software-conversion override, bit3 global software trigger, bit4 level software trigger), 2 = scan mask in bits 7:0. Address 3 reads 0.
- R4: Code 0 means no trigger. Such a channel never gets a request.
- R5: Code 1 follows the global software trigger bit. Writing 1 to it produces one request, and the bit then reads 0 from the cycle after the trigger on.
- R6: Code 2 follows the level software trigger bit. It gives one request when the bit goes from 0 to 1.
- R7: Code 3 follows `scan_trig`, but only for channels whose scan-mask bit is 1.
- R8: Code 4 follows `sync_trig`.
- R9: Codes 5 to 15 follow `evt_in[0]` to `evt_in[10]`, and only while the event-start enable bit is 1. While that bit is 0, these sources produce no request.
- R10: While the enable bit is 1, a write to the source register leaves it unchanged, and `bus_err` is 1 for one cycle after that write. Reads still return the stored value.
- R11: While the software-conversion override is 1, no channel gets a request.
- R12: A request is a one-cycle pulse on `start_req[k]`, in the clock after the first edge at which the channel's qualified trigger is sampled high. A held trigger gives no further pulse.
- R13: All channels that select the same source get their requests in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| bus_err | output | 1 | Error response, one cycle after a refused write |
| scan_trig | input | 1 | Scan trigger level |
| sync_trig | input | 1 | Synchronous trigger level |
| evt_in | input | 11 | Event trigger levels, already synchronous |
| start_req | output | 8 | Per-channel start-of-conversion pulses |

## Verification
The hardest situation to reach is the self-clearing software trigger. The bit lives for exactly one cycle, so the bench must see its request pulse and its readback of 0 in consecutive cycles. The bench gets there by writing the control register and then sampling the request vector and the control readback on the next two falling edges. The masked event path is also hard to reach, because the bench must show that a rising event input gives nothing while the event-start enable is 0. The bench therefore holds two event inputs high across the masked window, then lowers them and re-arms them before it expects any pulse.

// File: rtl/trig_route_pkg.sv
package trig_route_pkg;

   // source codes held in each channel field
   localparam int unsigned CODE_NONE     = 0;
   localparam int unsigned CODE_GSW      = 1;
   localparam int unsigned CODE_LSW      = 2;
   localparam int unsigned CODE_SCAN     = 3;
   localparam int unsigned CODE_SYNC     = 4;
   localparam int unsigned CODE_EVT_BASE = 5;

   // register addresses
   localparam int unsigned ADDR_SRC  = 0;
   localparam int unsigned ADDR_CTL  = 1;
   localparam int unsigned ADDR_SCAN = 2;

   // control bit positions
   localparam int unsigned CTL_EN  = 0;
   localparam int unsigned CTL_EVT = 1;
   localparam int unsigned CTL_SWC = 2;
   localparam int unsigned CTL_GSW = 3;
   localparam int unsigned CTL_LSW = 4;
   localparam int unsigned CTL_W   = 5;

   typedef struct packed {
      logic lsw;     // level software trigger
      logic gsw;     // global software trigger, self clearing
      logic swc;     // software conversion override
      logic evt_en;  // event start enable
      logic en;      // converter enable, locks the source register
   } ctl_t;

endpackage

// File: rtl/trig_route_regs.sv
module trig_route_regs
   import trig_route_pkg::*;
#(
   parameter int unsigned NUM_CH  = 8,
   parameter int unsigned FIELD_W = 4,
   parameter int unsigned ADDR_W  = 2,
   localparam int unsigned REG_W  = NUM_CH * FIELD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   output logic              bus_err,
   output logic [REG_W-1:0]  src_fields,
   output logic [NUM_CH-1:0] scan_sel,
   output ctl_t              ctl
);

   localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'(ADDR_SRC);
   localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(ADDR_CTL);
   localparam logic [ADDR_W-1:0] A_SCAN = ADDR_W'(ADDR_SCAN);

   initial begin : p_cfg
      a_cfg_ctl_fits: assert (REG_W >= CTL_W && REG_W >= NUM_CH)
         else $error("data width too small for control or scan mask");
      a_cfg_addr_fits: assert ((1 << ADDR_W) > ADDR_SCAN)
         else $error("address width too small");
   end

   logic [REG_W-1:0]  src_q;
   logic [NUM_CH-1:0] scan_q;
   ctl_t              ctl_q;
   logic              err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= '0;
         scan_q <= '0;
         ctl_q  <= '0;
         err_q  <= 1'b0;
      end else begin
         err_q <= 1'b0;
         // the trigger was produced while the bit was set, so drop it now
         if (ctl_q.gsw) ctl_q.gsw <= 1'b0;
         if (bus_wr) begin
            unique case (bus_addr)
               A_SRC: begin
                  if (ctl_q.en) err_q <= 1'b1;
                  else          src_q <= bus_wdata;
               end
               A_CTL:  ctl_q  <= ctl_t'(bus_wdata[CTL_W-1:0]);
               A_SCAN: scan_q <= bus_wdata[NUM_CH-1:0];
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         A_SRC:  bus_rdata = src_q;
         A_CTL:  bus_rdata[CTL_W-1:0] = ctl_q;
         A_SCAN: bus_rdata[NUM_CH-1:0] = scan_q;
         default: ;
      endcase
   end

   assign bus_err    = err_q;
   assign src_fields = src_q;
   assign scan_sel   = scan_q;
   assign ctl        = ctl_q;

   // R10: a write while enabled never alters the source register
   a_r10_src_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_SRC && ctl_q.en) |=> $stable(src_q));

   // R10: a refused write answers with an error
   a_r10_err_reply: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_SRC && ctl_q.en) |=> bus_err);

   // R5: the software pulse bit lasts a single cycle unless rewritten
   a_r5_gsw_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q.gsw && !(bus_wr && bus_addr == A_CTL && bus_wdata[CTL_GSW]))
      |=> !ctl_q.gsw);

endmodule

// File: rtl/trig_route_mux.sv
module trig_route_mux
   import trig_route_pkg::*;
#(
   parameter int unsigned NUM_CH  = 8,
   parameter int unsigned FIELD_W = 4,
   parameter int unsigned NUM_EVT = 11,
   localparam int unsigned REG_W  = NUM_CH * FIELD_W
) (
   input  logic [REG_W-1:0]   src_fields,
   input  logic [NUM_CH-1:0]  scan_sel,
   input  ctl_t               ctl,
   input  logic               scan_trig,
   input  logic               sync_trig,
   input  logic [NUM_EVT-1:0] evt_in,
   output logic [NUM_CH-1:0]  lvl
);

   initial begin : p_cfg
      a_cfg_evt_codes: assert (CODE_EVT_BASE + NUM_EVT <= (1 << FIELD_W))
         else $error("event inputs exceed field code space");
   end

   logic [NUM_EVT-1:0] evt_q;
   assign evt_q = ctl.evt_en ? evt_in : '0;

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      logic [FIELD_W-1:0] code;
      logic               hit;

      assign code = src_fields[k*FIELD_W +: FIELD_W];

      always_comb begin
         hit = 1'b0;
         if (code == FIELD_W'(CODE_GSW))       hit = ctl.gsw;
         else if (code == FIELD_W'(CODE_LSW))  hit = ctl.lsw;
         else if (code == FIELD_W'(CODE_SCAN)) hit = scan_trig & scan_sel[k];
         else if (code == FIELD_W'(CODE_SYNC)) hit = sync_trig;
         else begin
            for (int e = 0; e < NUM_EVT; e++) begin
               if (code == FIELD_W'(CODE_EVT_BASE + e)) hit = evt_q[e];
            end
         end
      end

      assign lvl[k] = hit & ~ctl.swc;
   end

endmodule

// File: rtl/trig_route_edge.sv
module trig_route_edge #(
   parameter int unsigned NUM_CH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] lvl,
   output logic [NUM_CH-1:0] start_req
);

   logic [NUM_CH-1:0] lvl_q;
   logic [NUM_CH-1:0] pulse_q;

   for (genvar k = 0; k < NUM_CH; k++) begin : g_det
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lvl_q[k]   <= 1'b0;
            pulse_q[k] <= 1'b0;
         end else begin
            lvl_q[k]   <= lvl[k];
            pulse_q[k] <= lvl[k] & ~lvl_q[k];
         end
      end
   end

   assign start_req = pulse_q;

   // R12: no channel is requested in two consecutive cycles
   a_r12_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req != '0) |=> ((start_req & $past(start_req)) == '0));

   // R12: a level already high in the previous cycle brings no new request
   a_r12_held_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl == $past(lvl) && $past(lvl) != '0) |=> ((start_req & lvl) == '0));

endmodule

// File: rtl/trig_route_top.sv
module trig_route_top
   import trig_route_pkg::*;
#(
   parameter int unsigned NUM_CH  = 8,
   parameter int unsigned FIELD_W = 4,
   parameter int unsigned NUM_EVT = 11,
   parameter int unsigned ADDR_W  = 2,
   localparam int unsigned REG_W  = NUM_CH * FIELD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [REG_W-1:0]   bus_wdata,
   output logic [REG_W-1:0]   bus_rdata,
   output logic               bus_err,
   input  logic               scan_trig,
   input  logic               sync_trig,
   input  logic [NUM_EVT-1:0] evt_in,
   output logic [NUM_CH-1:0]  start_req
);

   logic [REG_W-1:0]  src_fields;
   logic [NUM_CH-1:0] scan_sel;
   ctl_t              ctl;
   logic [NUM_CH-1:0] lvl;

   trig_route_regs #(
      .NUM_CH (NUM_CH),
      .FIELD_W(FIELD_W),
      .ADDR_W (ADDR_W)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .bus_err   (bus_err),
      .src_fields(src_fields),
      .scan_sel  (scan_sel),
      .ctl       (ctl)
   );

   trig_route_mux #(
      .NUM_CH (NUM_CH),
      .FIELD_W(FIELD_W),
      .NUM_EVT(NUM_EVT)
   ) i_mux (
      .src_fields(src_fields),
      .scan_sel  (scan_sel),
      .ctl       (ctl),
      .scan_trig (scan_trig),
      .sync_trig (sync_trig),
      .evt_in    (evt_in),
      .lvl       (lvl)
   );

   trig_route_edge #(
      .NUM_CH(NUM_CH)
   ) i_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (lvl),
      .start_req(start_req)
   );

   // R11: override active means no request in the following cycle
   a_r11_swc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.swc |=> (start_req == '0));

   for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
      // R4: a channel with code zero is never requested
      a_r4_none_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         (src_fields[k*FIELD_W +: FIELD_W] == '0) |=> !start_req[k]);
   end

endmodule

// File: tb/test_trig_route_top.sv
`timescale 1ns/1ps
module test_trig_route_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_err;
   logic        scan_trig = 1'b0;
   logic        sync_trig = 1'b0;
   logic [10:0] evt_in = '0;
   logic [7:0]  start_req;

   int checks = 0;
   int errors = 0;
   logic [4:0] ctl_sh = '0;   // bench copy of the control bits

   localparam logic [31:0] SRC_MIX = 32'h01F5_3324;

   always #4 clk = ~clk;

   trig_route_top i_trig_route_top (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
      .scan_trig(scan_trig), .sync_trig(sync_trig), .evt_in(evt_in),
      .start_req(start_req)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive at a falling edge, return one falling edge later
   task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic set_ctl(input logic [4:0] v);
      ctl_sh = v;
      bus_write(2'd1, {27'd0, v});
   endtask

   task automatic t_reset;
      logic [31:0] d;
      chk("R1 start", {24'd0, start_req}, 32'd0);
      bus_read(2'd0, d); chk("R1 src", d, 32'd0);
      bus_read(2'd1, d); chk("R1 ctl", d, 32'd0);
      bus_read(2'd2, d); chk("R1 scan", d, 32'd0);
   endtask

   task automatic t_program;
      logic [31:0] d;
      bus_write(2'd0, SRC_MIX);
      chk("R2 no err", {31'd0, bus_err}, 32'd0);
      bus_read(2'd0, d); chk("R2 readback", d, SRC_MIX);
      bus_write(2'd2, 32'h0000_0004);
      bus_read(2'd2, d); chk("R3 scan mask", d, 32'h4);
      bus_read(2'd3, d); chk("R3 unmapped", d, 32'd0);
   endtask

   task automatic t_sync;
      @(negedge clk); sync_trig = 1'b1;
      @(negedge clk); chk("R8 sync pulse", {24'd0, start_req}, 32'h01);
      @(negedge clk); chk("R12 sync held", {24'd0, start_req}, 32'h00);
      sync_trig = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_lsw;
      set_ctl(5'b10000);
      chk("R6 lsw wait", {24'd0, start_req}, 32'h00);
      @(negedge clk); chk("R6 lsw pulse", {24'd0, start_req}, 32'h02);
      @(negedge clk); chk("R12 lsw held", {24'd0, start_req}, 32'h00);
      set_ctl(5'b00000);
      @(negedge clk);
   endtask

   task automatic t_scan;
      scan_trig = 1'b1;
      @(negedge clk); chk("R7 scan gated", {24'd0, start_req}, 32'h04);
      scan_trig = 1'b0;
      bus_write(2'd2, 32'h0000_000C);
      scan_trig = 1'b1;
      @(negedge clk); chk("R7 scan both", {24'd0, start_req}, 32'h0C);
      scan_trig = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_events;
      evt_in[0] = 1'b1; evt_in[10] = 1'b1;
      @(negedge clk); chk("R9 masked a", {24'd0, start_req}, 32'h00);
      @(negedge clk); chk("R9 masked b", {24'd0, start_req}, 32'h00);
      evt_in = '0;
      set_ctl(5'b00010);
      @(negedge clk);
      evt_in[0] = 1'b1;
      @(negedge clk); chk("R9 evt0", {24'd0, start_req}, 32'h10);
      evt_in[0] = 1'b0; evt_in[10] = 1'b1;
      @(negedge clk); chk("R9 evt10", {24'd0, start_req}, 32'h20);
      evt_in = '0;
      @(negedge clk);
   endtask

   task automatic t_gsw;
      logic [31:0] d;
      set_ctl(5'b01000);
      chk("R5 gsw wait", {24'd0, start_req}, 32'h00);
      @(negedge clk); chk("R5 gsw pulse", {24'd0, start_req}, 32'h40);
      bus_read(2'd1, d); chk("R5 gsw cleared", d, 32'd0);
      @(negedge clk); chk("R5 gsw single", {24'd0, start_req}, 32'h00);
   endtask

   task automatic t_shared;
      bus_write(2'd0, 32'h0000_0044);
      sync_trig = 1'b1;
      @(negedge clk); chk("R13 shared", {24'd0, start_req}, 32'h03);
      chk("R4 none ch7", {31'd0, start_req[7]}, 32'd0);
      sync_trig = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_lock;
      logic [31:0] d;
      set_ctl(5'b00001);
      bus_write(2'd0, 32'hFFFF_FFFF);
      chk("R10 err", {31'd0, bus_err}, 32'd1);
      bus_read(2'd0, d); chk("R10 unchanged", d, 32'h0000_0044);
      @(negedge clk); chk("R10 err one cycle", {31'd0, bus_err}, 32'd0);
      set_ctl(5'b00000);
      bus_write(2'd0, 32'h0000_0004);
      chk("R10 unlocked no err", {31'd0, bus_err}, 32'd0);
      bus_read(2'd0, d); chk("R2 written", d, 32'h4);
   endtask

   task automatic t_swc;
      set_ctl(5'b00100);
      sync_trig = 1'b1;
      @(negedge clk); chk("R11 quiet a", {24'd0, start_req}, 32'h00);
      @(negedge clk); chk("R11 quiet b", {24'd0, start_req}, 32'h00);
      sync_trig = 1'b0;
      set_ctl(5'b00000);
      @(negedge clk);
   endtask

   initial begin : p_watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : p_main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_program;
      t_sync;
      t_lsw;
      t_scan;
      t_events;
      t_gsw;
      t_shared;
      t_lock;
      t_swc;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule